// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block decides which of two reference clocks feeds one PLL channel, and it watches both references for activity. Each reference passes through a two-flop synchronizer into the sampling clock domain, where a rising-edge detector drives an activity monitor. The monitor marks the input as lost after a programmable run of cycles with no edge. It marks the input as usable again after a programmable number of edges with no timeout between them.

A two-bit mode input picks one of four selection policies. Two are manual: one follows a pin, the other follows a select bit. Two are automatic: both fail over to the other input when the active input drops out. One of them returns to the primary input once it recovers, and the other stays where it is. The meaning of the select bit depends on the mode. It either commands the input, names the primary, or is ignored. Both the select index and the loss flags are registered. The clock mux that acts on the decision sits outside this block.

Top module: `dual_ref_selector`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sel_o` is 0 and `lost_o` is 2'b11.
- R2: A reference's loss flag (bit i of `lost_o` for `ref_clk_i[i]`) goes to 1 when `loss_limit_i` consecutive sampling cycles pass with no detected rising edge on that reference.
- R3: A lost reference's flag returns to 0 after `good_count_i` detected rising edges with no timeout between them. A rising edge on a reference is detected on the third sampling edge after it appears.
- R4: With mode 2'b00, `sel_o` equals the `sel_pin_i` value from the previous cycle, and `sel_reg_i` has no effect.
- R5: With mode 2'b11, `sel_o` equals the previous cycle's `sel_reg_i` (0 picks reference 0, 1 picks reference 1).
- R6: On the cycle after entering mode 2'b01 or 2'b10 from any other mode, `sel_o` becomes the primary named by `sel_reg_i` if that input is not lost. Otherwise it becomes the other input if that one is not lost. Otherwise it holds.
- R7: In an automatic mode, when the selected input is lost and the other is not, `sel_o` moves to the other input. It never moves onto a lost input, and it holds when both inputs are lost.
- R8: In mode 2'b10 (revertive), when the selection is not the primary and the primary is not lost, `sel_o` returns to the primary.
- R9: In mode 2'b01 (non-revertive), `sel_o` changes only when the selected input is lost; a recovered primary does not pull the selection back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 2 | The two reference clocks, asynchronous to clk |
| sel_pin_i | input | 1 | Select pin used in mode 2'b00 |
| mode_i | input | 2 | 00 pin manual, 01 auto non-revertive, 10 auto revertive, 11 register manual |
| sel_reg_i | input | 1 | Commanded input (mode 11) or primary (modes 01/10) |
| loss_limit_i | input | CNT_W | Idle sampling cycles that declare an input lost |
| good_count_i | input | RUN_W | Edge intervals needed to requalify an input |
| sel_o | output | 1 | Selected reference index |
| lost_o | output | 2 | Per-input loss flags, bit i for ref_clk_i[i] |

## Verification
The hardest situation to reach is entry into an automatic mode while the primary is lost and only the backup is qualified. It needs one reference stopped long enough to time out, the other restarted long enough to requalify, and only then a mode change. The stimulus gets there in steps. It stops both references, parks the selection with the pin, restarts only reference 0, waits out the qualification, and then enters revertive mode with reference 1 named as primary. Fail-over, revert and non-revert paths are reached by stopping and restarting the reference generators in the bench one at a time.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_PIN         = 2'b00,
    MODE_AUTO_HOLD   = 2'b01,
    MODE_AUTO_REVERT = 2'b10,
    MODE_REG         = 2'b11
  } sel_mode_e;

  function automatic logic mode_is_auto(input logic [1:0] m);
    return (m == MODE_AUTO_HOLD) || (m == MODE_AUTO_REVERT);
  endfunction
endpackage

// File: rtl/refsel_edge_sync.sv
module refsel_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/refsel_activity_mon.sv
module refsel_activity_mon #(
  parameter int CNT_W = 8,
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] loss_limit_i,
  input  logic [RUN_W-1:0] good_count_i,
  output logic             lost_o
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;

  logic [CNT_W-1:0] gap_q, gap_next;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_inc;
  logic             lost_q;

  always_comb begin
    gap_next = (gap_q == GAP_MAX) ? gap_q : gap_q + 1'b1;
    run_inc  = {1'b0, run_q} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      run_q  <= '0;
      lost_q <= 1'b1;
    end else if (edge_i) begin
      gap_q <= '0;
      if (lost_q) begin
        if (run_inc >= {1'b0, good_count_i}) begin
          lost_q <= 1'b0;
          run_q  <= '0;
        end else begin
          run_q <= run_inc[RUN_W-1:0];
        end
      end
    end else begin
      gap_q <= gap_next;
      if (gap_next >= loss_limit_i) begin
        lost_q <= 1'b1;
        run_q  <= '0;
      end
    end
  end

  assign lost_o = lost_q;

  a_r2_loss_needs_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_q) |-> !$past(edge_i));
  a_r3_clear_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(lost_q) |-> $past(edge_i));
endmodule

// File: rtl/refsel_choose.sv
module refsel_choose
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       sel_pin_i,
  input  logic       sel_reg_i,
  input  logic [1:0] lost_i,
  output logic       sel_o
);
  logic [1:0] mode_q;
  logic       sel_q, sel_d;
  logic       entering, prim, other;

  always_comb begin
    prim     = sel_reg_i;
    other    = ~sel_q;
    entering = mode_is_auto(mode_i) && (mode_q != mode_i);
    sel_d    = sel_q;
    case (mode_i)
      MODE_PIN: sel_d = sel_pin_i;
      MODE_REG: sel_d = sel_reg_i;
      default: begin
        if (entering) begin
          if (!lost_i[prim])       sel_d = prim;
          else if (!lost_i[~prim]) sel_d = ~prim;
        end else if (lost_i[sel_q] && !lost_i[other]) begin
          sel_d = other;
        end else if ((mode_i == MODE_AUTO_REVERT) && (sel_q != prim) && !lost_i[prim]) begin
          sel_d = prim;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PIN;
      sel_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      sel_q  <= sel_d;
    end
  end

  assign sel_o = sel_q;

  a_r4_pin_follows: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_PIN) |=> (sel_q == $past(sel_pin_i)));
  a_r5_reg_follows: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_REG) |=> (sel_q == $past(sel_reg_i)));
  a_r7_never_onto_lost: assert property (@(posedge clk) disable iff (rst)
    (mode_is_auto($past(mode_i)) && (sel_q != $past(sel_q)))
      |-> !(sel_q ? $past(lost_i[1]) : $past(lost_i[0])));
  a_r9_hold_unless_lost: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_i) == MODE_AUTO_HOLD) && ($past(mode_q) == MODE_AUTO_HOLD) && (sel_q != $past(sel_q)))
      |-> ($past(sel_q) ? $past(lost_i[1]) : $past(lost_i[0])));
endmodule

// File: rtl/dual_ref_selector.sv
module dual_ref_selector #(
  parameter int CNT_W       = 8,
  parameter int RUN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ref_clk_i,
  input  logic             sel_pin_i,
  input  logic [1:0]       mode_i,
  input  logic             sel_reg_i,
  input  logic [CNT_W-1:0] loss_limit_i,
  input  logic [RUN_W-1:0] good_count_i,
  output logic             sel_o,
  output logic [1:0]       lost_o
);
  localparam int NUM_REF = 2;

  logic [NUM_REF-1:0] rise;
  logic [NUM_REF-1:0] lost;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
    refsel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (ref_clk_i[i]),
      .rise_o  (rise[i])
    );
    refsel_activity_mon #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .edge_i       (rise[i]),
      .loss_limit_i (loss_limit_i),
      .good_count_i (good_count_i),
      .lost_o       (lost[i])
    );
  end

  refsel_choose u_choose (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .sel_pin_i (sel_pin_i),
    .sel_reg_i (sel_reg_i),
    .lost_i    (lost),
    .sel_o     (sel_o)
  );

  assign lost_o = lost;
endmodule

// File: tb/dual_ref_selector_tb_top.sv
module dual_ref_selector_tb_top;
  localparam int CW = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ref_clk = 2'b00;
  logic          sel_pin = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          sel_reg = 1'b0;
  logic [CW-1:0] loss_limit = 8'd10;
  logic [RW-1:0] good_count = 4'd3;
  logic          sel;
  logic [1:0]    lost;

  always #4 clk = ~clk;

  dual_ref_selector #(.CNT_W(CW), .RUN_W(RW)) dut_i (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .sel_pin_i(sel_pin),
    .mode_i(mode), .sel_reg_i(sel_reg), .loss_limit_i(loss_limit),
    .good_count_i(good_count), .sel_o(sel), .lost_o(lost));

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R1";
  bit    done = 0;

  // reference generators
  bit run_en[2] = '{1, 1};
  int per[2]    = '{4, 6};
  int cnt[2]    = '{0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (run_en[i]) begin
        cnt[i]++;
        ref_clk[i] <= ((cnt[i] % per[i]) < per[i] / 2);
      end else begin
        ref_clk[i] <= 1'b0;
      end
    end
  end

  // behavioural reference model
  int   m_gap[2];
  int   m_run[2];
  bit   m_lost[2];
  bit   m_sel;
  int   m_mode_prev;
  bit   hist0[$];
  bit   hist1[$];

  function automatic bit is_auto(int m);
    return (m == 1) || (m == 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_gap[i] = 0; m_run[i] = 0; m_lost[i] = 1;
      end
      m_sel = 0; m_mode_prev = 0;
      hist0 = '{0, 0, 0, 0};
      hist1 = '{0, 0, 0, 0};
    end else begin
      bit ns;
      bit ev[2];
      int md;
      bit pr;
      md = int'(mode);
      pr = sel_reg;
      ns = m_sel;
      if (md == 0) ns = sel_pin;
      else if (md == 3) ns = sel_reg;
      else if (md != m_mode_prev) begin
        if (!m_lost[pr]) ns = pr;
        else if (!m_lost[!pr]) ns = !pr;
      end else if (m_lost[m_sel] && !m_lost[!m_sel]) ns = !m_sel;
      else if (md == 2 && m_sel != pr && !m_lost[pr]) ns = pr;
      m_sel = ns;
      m_mode_prev = md;
      ev[0] = hist0[1] && !hist0[2];
      ev[1] = hist1[1] && !hist1[2];
      for (int i = 0; i < 2; i++) begin
        if (ev[i]) begin
          m_gap[i] = 0;
          if (m_lost[i]) begin
            if (m_run[i] + 1 >= int'(good_count)) begin
              m_lost[i] = 0; m_run[i] = 0;
            end else m_run[i]++;
          end
        end else begin
          if (m_gap[i] < 255) m_gap[i]++;
          if (m_gap[i] >= int'(loss_limit)) begin
            m_lost[i] = 1; m_run[i] = 0;
          end
        end
      end
      hist0.push_front(ref_clk[0]); void'(hist0.pop_back());
      hist1.push_front(ref_clk[1]); void'(hist1.pop_back());
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (sel !== m_sel || lost !== {m_lost[1], m_lost[0]}) begin
        miscompares++;
        $display("FAIL %s: sel=%0d lost=%b expected sel=%0d lost=%b", phase,
                 sel, lost, m_sel, {m_lost[1], m_lost[0]});
      end
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    wait_cyc(4);
    check("R1 sel in reset", int'(sel), 0);
    check("R1 lost in reset", int'(lost), 3);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 sel after reset", int'(sel), 0);
    check("R1 lost after reset", int'(lost), 3);

    phase = "R4"; mode = 2'b00;
    sel_pin = 1; sel_reg = 0; wait_cyc(2);
    check("R4 pin picks 1", int'(sel), 1);
    sel_pin = 0; sel_reg = 1; wait_cyc(2);
    check("R4 pin picks 0, reg ignored", int'(sel), 0);
    wait_cyc(40);
    check("R3 both qualified", int'(lost), 0);

    phase = "R5"; mode = 2'b11;
    sel_pin = 0; sel_reg = 1; wait_cyc(2);
    check("R5 reg picks 1", int'(sel), 1);
    sel_pin = 1; sel_reg = 0; wait_cyc(2);
    check("R5 reg picks 0", int'(sel), 0);

    phase = "R6"; mode = 2'b10; sel_reg = 1; wait_cyc(2);
    check("R6 entry on primary", int'(sel), 1);
    phase = "R7"; run_en[1] = 0; wait_cyc(20);
    check("R2 ref1 lost", int'(lost), 2);
    check("R7 failover to 0", int'(sel), 0);
    phase = "R8"; run_en[1] = 1; wait_cyc(40);
    check("R3 ref1 requalified", int'(lost), 0);
    check("R8 revert to primary", int'(sel), 1);

    phase = "R9"; mode = 2'b00; sel_pin = 0; wait_cyc(2);
    mode = 2'b01; sel_reg = 0; wait_cyc(2);
    check("R6 entry non-revertive", int'(sel), 0);
    run_en[0] = 0; wait_cyc(20);
    check("R7 failover to 1", int'(sel), 1);
    run_en[0] = 1; wait_cyc(40);
    check("R9 ref0 back", int'(lost), 0);
    check("R9 stays on backup", int'(sel), 1);
    phase = "R7"; run_en[1] = 0; wait_cyc(20);
    check("R7 back to 0", int'(sel), 0);
    run_en[0] = 0; wait_cyc(20);
    check("R2 both lost", int'(lost), 3);
    check("R7 hold with both lost", int'(sel), 0);

    phase = "R6"; mode = 2'b00; sel_pin = 1; wait_cyc(2);
    check("R4 pin picks 1 again", int'(sel), 1);
    run_en[0] = 1; wait_cyc(40);
    check("R3 only ref0 valid", int'(lost), 2);
    mode = 2'b10; sel_reg = 1; wait_cyc(2);
    check("R6 entry falls back to 0", int'(sel), 0);

    wait_cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule